// File: doc/BRIEF.md
# Write Guard and Program Timer for a Serial EEPROM

This block sits behind the serial front end of a small EEPROM model. The front end decodes opcodes and, once chip select rises, hands over one finished request per cycle: set the write-enable latch, clear it, write the protect bits, or write a page. The guard decides whether the request is legal, given three things: the write-protect pin, the enable latch, and the two block-protect bits. It runs a self-timed programming interval of a fixed number of system clocks. It then either updates the protect bits or issues one array write strobe per buffered byte.

The front end keeps the page buffer. The guard tells it which buffer slot to supply on each strobe, and which array address that slot lands on. The guard also produces the status byte that the front end shifts out for a status read. While a cycle is in progress, that status byte is the only thing the front end should use.

Top module: `eeprom_write_guard`

## Requirements
- R1: After reset, the status byte reads 0x00, busy is 0 and no array strobe is issued.
- R2: Status byte layout: bits 7..4 always read 0; bit 3 is protect bit 1; bit 2 is protect bit 0; bit 1 is the enable latch; bit 0 is busy.
- R3: With the block idle, command kind 0 sets the enable latch and kind 1 clears it. The change is visible one cycle after the request. Neither command depends on the write-protect pin.
- R4: When `wp_n` is 0, a status write (kind 2) and a page write (kind 3) are both refused: busy stays 0 and nothing changes.
- R5: When the enable latch is 0, status writes and page writes are refused.
- R6: An accepted status write raises busy for exactly PROG_CYCLES cycles. When busy falls, the protect bits take `cmd_sdata[3:2]` and the enable latch clears. All other data bits are ignored.
- R7: The protect level selects a range. Level 00 protects nothing; 01 protects 0x600-0x7FF; 10 protects 0x400-0x7FF; 11 protects the whole array. A page write whose page lies in the protected range is refused as a whole.
- R8: An accepted page write holds busy for PROG_CYCLES cycles. It then issues one strobe per byte on consecutive cycles, with slot indices 0 to len-1. Strobe k writes address {page bits, (start low nibble + k) mod 16}. Busy falls after the last strobe, and the enable latch clears at the same time.
- R9: Once a cycle is accepted, `wp_n` falling has no effect on it.
- R10: While busy, every request is ignored, including enable set and clear.
- R11: A page write with length 0 is refused. A length above 16 is treated as 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wp_n | input | 1 | Write-protect pin, low refuses writes |
| cmd_valid | input | 1 | One-cycle request strobe |
| cmd_kind | input | 2 | 0 enable set, 1 enable clear, 2 status write, 3 page write |
| cmd_addr | input | 11 | Page write start address |
| cmd_len | input | 5 | Page write byte count |
| cmd_sdata | input | 8 | Status write data |
| status_o | output | 8 | Status byte |
| busy_o | output | 1 | Programming cycle in progress |
| arr_we_o | output | 1 | Array write strobe |
| arr_addr_o | output | 11 | Array address of the current strobe |
| arr_slot_o | output | 4 | Page buffer slot of the current strobe |

## Verification
A wrong enable latch or wrong protect bits show up on the status byte one cycle after the request that corrupted them. Their effect is also visible in the next write request: busy rises or fails to rise on the cycle after it. A miscounting timer shows as busy falling early or late, and as strobes shifted by whole cycles. An address wrap error shows on the strobe address as soon as the low nibble crosses 15. A reference model compares every output on every cycle, so each such fault is reported in the cycle it first appears.

// File: rtl/ewg_pkg.sv
package ewg_pkg;
  typedef enum logic [1:0] {
    CMD_WEN_SET    = 2'd0,
    CMD_WEN_CLR    = 2'd1,
    CMD_SR_WRITE   = 2'd2,
    CMD_PAGE_WRITE = 2'd3
  } cmd_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PROG  = 2'd1,
    ST_APPLY = 2'd2
  } ewg_state_e;
endpackage

// File: rtl/ewg_permit.sv
module ewg_permit #(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 4
) (
  input  logic              wp_n,
  input  logic              wen,
  input  logic [1:0]        bp,
  input  logic [1:0]        kind,
  input  logic [ADDR_W-1:0] addr,
  input  logic [PAGE_W:0]   len,
  output logic              allow
);
  import ewg_pkg::*;

  logic page_prot;
  logic gate;

  always_comb begin
    case (bp)
      2'b00:   page_prot = 1'b0;
      2'b01:   page_prot = &addr[ADDR_W-1:ADDR_W-2];
      2'b10:   page_prot = addr[ADDR_W-1];
      default: page_prot = 1'b1;
    endcase
  end

  assign gate = wp_n & wen;

  always_comb begin
    case (kind)
      CMD_SR_WRITE:   allow = gate;
      CMD_PAGE_WRITE: allow = gate & ~page_prot & (len != '0);
      default:        allow = 1'b0;
    endcase
  end
endmodule

// File: rtl/ewg_timer.sv
module ewg_timer #(
  parameter int CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic done
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          run_q, run_d;

  assign done = run_q && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    run_d = run_q;
    if (start) begin
      cnt_d = '0;
      run_d = 1'b1;
    end else if (run_q) begin
      if (done) begin
        run_d = 1'b0;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end

  // R6/R8: the interval counter never passes its last value
  assert_cnt_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt_q <= LAST));
  // R10: a new interval is never started on top of a running one
  assert_no_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !run_q);
endmodule

// File: rtl/eeprom_write_guard.sv
module eeprom_write_guard #(
  parameter int ADDR_W      = 11,
  parameter int PAGE_W      = 4,
  parameter int PROG_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_kind,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [PAGE_W:0]   cmd_len,
  input  logic [7:0]        cmd_sdata,
  output logic [7:0]        status_o,
  output logic              busy_o,
  output logic              arr_we_o,
  output logic [ADDR_W-1:0] arr_addr_o,
  output logic [PAGE_W-1:0] arr_slot_o
);
  import ewg_pkg::*;

  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam logic [PAGE_W:0] PAGE_FULL = (PAGE_W + 1)'(PAGE_BYTES);

  ewg_state_e        state_q, state_d;
  logic              wen_q, wen_d;
  logic [1:0]        bp_q, bp_d;
  logic              is_sr_q, is_sr_d;
  logic [ADDR_W-1:0] base_q, base_d;
  logic [PAGE_W:0]   len_q, len_d;
  logic [PAGE_W-1:0] idx_q, idx_d;
  logic [1:0]        sd_q, sd_d;
  logic              allow, accept, tdone;
  logic [PAGE_W:0]   len_eff;
  logic              unused_sdata;

  assign unused_sdata = ^{cmd_sdata[7:4], cmd_sdata[1:0]};
  assign len_eff = (cmd_len > PAGE_FULL) ? PAGE_FULL : cmd_len;

  ewg_permit #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_permit (
    .wp_n (wp_n),
    .wen  (wen_q),
    .bp   (bp_q),
    .kind (cmd_kind),
    .addr (cmd_addr),
    .len  (len_eff),
    .allow(allow)
  );

  assign accept = cmd_valid && (state_q == ST_IDLE) && allow;

  ewg_timer #(.CYCLES(PROG_CYCLES)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .start(accept),
    .done (tdone)
  );

  always_comb begin
    state_d = state_q;
    wen_d   = wen_q;
    bp_d    = bp_q;
    is_sr_d = is_sr_q;
    base_d  = base_q;
    len_d   = len_q;
    idx_d   = idx_q;
    sd_d    = sd_q;
    case (state_q)
      ST_IDLE: begin
        if (cmd_valid) begin
          if (cmd_kind == CMD_WEN_SET) wen_d = 1'b1;
          if (cmd_kind == CMD_WEN_CLR) wen_d = 1'b0;
        end
        if (accept) begin
          state_d = ST_PROG;
          is_sr_d = (cmd_kind == CMD_SR_WRITE);
          base_d  = cmd_addr;
          len_d   = len_eff;
          sd_d    = cmd_sdata[3:2];
          idx_d   = '0;
        end
      end
      ST_PROG: begin
        if (tdone) begin
          if (is_sr_q) begin
            bp_d    = sd_q;
            wen_d   = 1'b0;
            state_d = ST_IDLE;
          end else begin
            state_d = ST_APPLY;
            idx_d   = '0;
          end
        end
      end
      ST_APPLY: begin
        if ({1'b0, idx_q} == len_q - 1'b1) begin
          state_d = ST_IDLE;
          wen_d   = 1'b0;
        end
        idx_d = idx_q + 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      wen_q   <= 1'b0;
      bp_q    <= 2'b00;
      is_sr_q <= 1'b0;
      base_q  <= '0;
      len_q   <= '0;
      idx_q   <= '0;
      sd_q    <= 2'b00;
    end else begin
      state_q <= state_d;
      wen_q   <= wen_d;
      bp_q    <= bp_d;
      is_sr_q <= is_sr_d;
      base_q  <= base_d;
      len_q   <= len_d;
      idx_q   <= idx_d;
      sd_q    <= sd_d;
    end
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign status_o   = {4'b0000, bp_q, wen_q, busy_o};
  assign arr_we_o   = (state_q == ST_APPLY);
  assign arr_slot_o = idx_q;
  assign arr_addr_o = {base_q[ADDR_W-1:PAGE_W], base_q[PAGE_W-1:0] + idx_q};

  // R2: the upper nibble of the status byte stays zero
  assert_status_upper_R2: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[7:4] == 4'b0000);
  // R4: a write request with the pin low never starts a cycle
  assert_pin_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && cmd_valid && cmd_kind[1] && !wp_n) |=> !busy_o);
  // R5: a write request with the latch clear never starts a cycle
  assert_latch_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && cmd_valid && cmd_kind[1] && !status_o[1]) |=> !busy_o);
  // R6/R8: the enable latch is clear whenever a cycle has just ended
  assert_wen_clear_at_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> !status_o[1]);
  // R6: protect bits change only as a status cycle ends
  assert_bp_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(busy_o) |-> $stable(status_o[3:2]));
  // R8: strobes only occur inside a busy cycle
  assert_we_in_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we_o |-> busy_o);
  // R10: the enable latch cannot change while a cycle runs
  assert_wen_hold_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(status_o[1]));
endmodule

// File: tb/tb_eeprom_write_guard.sv
module tb_eeprom_write_guard;
  localparam int CLK_PERIOD = 10;
  localparam int P          = 20;
  localparam int WATCHDOG   = 20000;

  logic        clk;
  logic        rst_n;
  logic        wp_n;
  logic        cmd_valid;
  logic [1:0]  cmd_kind;
  logic [10:0] cmd_addr;
  logic [4:0]  cmd_len;
  logic [7:0]  cmd_sdata;
  logic [7:0]  status_o;
  logic        busy_o;
  logic        arr_we_o;
  logic [10:0] arr_addr_o;
  logic [3:0]  arr_slot_o;

  eeprom_write_guard #(.ADDR_W(11), .PAGE_W(4), .PROG_CYCLES(P)) dut (
    .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .cmd_valid(cmd_valid),
    .cmd_kind(cmd_kind), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
    .cmd_sdata(cmd_sdata), .status_o(status_o), .busy_o(busy_o),
    .arr_we_o(arr_we_o), .arr_addr_o(arr_addr_o), .arr_slot_o(arr_slot_o)
  );

  int    vectors = 0;
  int    errors  = 0;
  int    cycles  = 0;
  string cur_req = "R1";
  bit    chk_en  = 0;

  // reference model state
  int m_wen, m_bp, m_busy, m_sr, m_t, m_len, m_base, m_sd;

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int prot(input int bp, input int a);
    if (bp == 1) return (a >= 'h600);
    if (bp == 2) return (a >= 'h400);
    if (bp == 3) return 1;
    return 0;
  endfunction

  always @(posedge clk) begin
    chk_en <= 1;
    if (!rst_n) begin
      m_wen = 0; m_bp = 0; m_busy = 0; m_sr = 0; m_t = 0; m_len = 0; m_base = 0; m_sd = 0;
    end else if (m_busy != 0) begin
      m_t = m_t + 1;
      if (m_sr != 0 && m_t == P) begin
        m_bp = m_sd; m_wen = 0; m_busy = 0;
      end else if (m_sr == 0 && m_t == P + m_len) begin
        m_wen = 0; m_busy = 0;
      end
    end else if (cmd_valid) begin
      int l;
      l = (cmd_len > 16) ? 16 : int'(cmd_len);
      case (cmd_kind)
        2'd0: m_wen = 1;
        2'd1: m_wen = 0;
        2'd2: if (wp_n && m_wen != 0) begin
          m_busy = 1; m_sr = 1; m_t = 0; m_sd = int'(cmd_sdata[3:2]);
        end
        default: if (wp_n && m_wen != 0 && l != 0 && prot(m_bp, int'(cmd_addr)) == 0) begin
          m_busy = 1; m_sr = 0; m_t = 0; m_len = l; m_base = int'(cmd_addr);
        end
      endcase
    end
  end

  always @(negedge clk) begin
    if (chk_en) begin
      int es, ewe, eslot, eaddr;
      es  = (m_bp << 2) | (m_wen << 1) | m_busy;
      ewe = (m_busy != 0 && m_sr == 0 && m_t >= P) ? 1 : 0;
      eslot = m_t - P;
      eaddr = (m_base & 'h7F0) | ((m_base + eslot) & 'hF);
      vectors++;
      if (int'(status_o) != es || int'(busy_o) != m_busy || int'(arr_we_o) != ewe) begin
        errors++;
        $display("FAIL %s: status %h busy %0d we %0d, expected status %h busy %0d we %0d",
                 cur_req, status_o, busy_o, arr_we_o, es[7:0], m_busy, ewe);
      end else if (ewe != 0) begin
        vectors++;
        if (int'(arr_addr_o) != eaddr || int'(arr_slot_o) != eslot) begin
          errors++;
          $display("FAIL %s: addr %h slot %0d, expected addr %h slot %0d",
                   cur_req, arr_addr_o, arr_slot_o, eaddr[10:0], eslot);
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      errors++;
      $display("FAIL %s: watchdog expired, got running expected finished", cur_req);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  task automatic issue(input int kind, input int addr, input int len, input int sd);
    @(negedge clk);
    cmd_valid = 1; cmd_kind = 2'(kind); cmd_addr = 11'(addr);
    cmd_len = 5'(len); cmd_sdata = 8'(sd);
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic idle_wait();
    while (busy_o) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    rst_n = 0; wp_n = 1; cmd_valid = 0; cmd_kind = 0; cmd_addr = 0; cmd_len = 0; cmd_sdata = 0;
    // R1 R2: reset state checked every cycle while held
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);

    cur_req = "R5";  // latch clear refuses both writes
    issue(3, 'h010, 4, 0);
    issue(2, 0, 0, 'h0C);
    repeat (2) @(negedge clk);

    cur_req = "R3";  // set, clear, set
    issue(0, 0, 0, 0);
    issue(1, 0, 0, 0);
    issue(0, 0, 0, 0);

    cur_req = "R4";  // pin low refuses
    wp_n = 0;
    issue(2, 0, 0, 'h0C);
    issue(3, 'h020, 2, 0);
    wp_n = 1;
    repeat (2) @(negedge clk);

    cur_req = "R6";  // only bits 3:2 land, latch clears
    issue(2, 0, 0, 'hF6);
    idle_wait();

    cur_req = "R7";  // level 01 refuses 0x600 page
    issue(0, 0, 0, 0);
    issue(3, 'h600, 4, 0);
    repeat (2) @(negedge clk);

    cur_req = "R8";  // allowed page below the range, wraps low nibble
    issue(3, 'h5FE, 4, 0);
    idle_wait();

    cur_req = "R11"; // zero length refused, oversize clamped
    issue(0, 0, 0, 0);
    issue(3, 'h0A0, 0, 0);
    repeat (2) @(negedge clk);
    issue(3, 'h0A5, 20, 0);
    idle_wait();

    cur_req = "R9";  // pin drop mid-cycle
    issue(0, 0, 0, 0);
    issue(3, 'h123, 3, 0);
    repeat (5) @(negedge clk);
    wp_n = 0;
    idle_wait();
    wp_n = 1;

    cur_req = "R10"; // requests during busy ignored
    issue(0, 0, 0, 0);
    issue(3, 'h040, 2, 0);
    issue(1, 0, 0, 0);
    issue(2, 0, 0, 'h0C);
    issue(0, 0, 0, 0);
    idle_wait();

    cur_req = "R7";  // level 10 then 11
    issue(0, 0, 0, 0);
    issue(2, 0, 0, 'h08);
    idle_wait();
    issue(0, 0, 0, 0);
    issue(3, 'h400, 1, 0);
    repeat (2) @(negedge clk);
    issue(3, 'h3F0, 2, 0);
    idle_wait();
    issue(0, 0, 0, 0);
    issue(2, 0, 0, 'h0C);
    idle_wait();
    issue(0, 0, 0, 0);
    issue(3, 'h000, 1, 0);
    repeat (3) @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule